// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of an 8192-byte nonvolatile memory. It watches the SPI pins from a system clock domain. SCK, CS and SI pass through a small synchronizer, and edges of SCK are detected with registers. The block decodes 8-bit commands and gathers a 16-bit address. It then runs endless read or write bursts against a synchronous array port: the address and write strobe go out, and read data returns one clock after the address.

Status is handled by a neighbouring block. The engine shows that block the status byte it must shift out, hands over a written status byte, and pulses requests to set or clear the write-enable latch. All protection is decided in that neighbour and comes back as two permit inputs: one for array writes at the current address and one for status writes. SPI modes 0 and 3 both work, because input bits are taken on rising SCK and output bits change only on falling SCK.

Each SCK level must last at least SYNC_STAGES + 3 system clocks.

Top module: `sfm_spi_slave`

## Requirements
- R1: SI is sampled on rising SCK and SO changes only on falling SCK, MSB first, with SCK idling either low (mode 0) or high (mode 3).
- R2: Op-code 0x06 gives one wel_set pulse and op-code 0x04 gives one wel_clr pulse; at most one of mem_we, stat_we, wel_set, wel_clr is high in any cycle.
- R3: Any op-code other than 0x06, 0x04, 0x05, 0x01, 0x03, 0x02 is ignored: no strobe is raised and SO stays undriven for the rest of the selection.
- R4: If CS rises before the eighth op-code bit has arrived, nothing is executed.
- R5: READ (0x03) takes a 16-bit address, MSB first, of which bits 12..0 select the location and bits 15..13 are ignored. The first data bit is valid after the falling SCK that follows the last address bit, and SI is ignored while data is returned.
- R6: Each further 8 clocks of a READ return the next address, and 0x1FFF is followed by 0x0000.
- R7: WRITE (0x02) takes the address the same way. Each complete data byte gives a single-cycle mem_we at the current address, and the address then increments with the same wrap from 0x1FFF to 0x0000.
- R8: A data byte cut short by CS rising is discarded and not written.
- R9: mem_we is raised only when mem_wr_ok is high, and stat_we only when sts_wr_ok is high.
- R10: RDSR (0x05) shifts out stat_rdata, repeating it for every 8 further clocks. WRSR (0x01) hands its first data byte to stat_wdata with one stat_we pulse.
- R11: spi_so_oe is low except while read or status data is being shifted out, and it falls one clock after the synchronized CS is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out (0 when not driven) |
| spi_so_oe | output | 1 | Output enable for SO; low means high impedance |
| mem_addr | output | AW | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe |
| mem_rdata | input | 8 | Array read data, one clock after mem_addr |
| mem_wr_ok | input | 1 | Array write permitted at mem_addr |
| stat_rdata | input | 8 | Status byte to shift out |
| stat_wdata | output | 8 | Status byte received |
| stat_we | output | 1 | Status write strobe |
| sts_wr_ok | input | 1 | Status write permitted |
| wel_set | output | 1 | Request to set the write-enable latch |
| wel_clr | output | 1 | Request to clear the write-enable latch |

## Verification
The bench keeps the defaults AW=13 and SYNC_STAGES=2, so the array has its real 8192-location size. Address wrap at 0x1FFF therefore happens on the true boundary, and address bits 15..13 really are discarded. Both synchronizer stages are in place, so the bench runs SCK at eight system clocks per level and SO is sampled with the full synchronizer and edge-detect delay in the path.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OP, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_RDSR, ST_WRSR, ST_SKIP
  } sfm_state_t;
endpackage

// File: rtl/sfm_sync.sv
module sfm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/sfm_addr_ctr.sv
module sfm_addr_ctr #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          inc,
  input  logic [7:0]    din,
  output logic [AW-1:0] addr
);
  localparam int HI_W = AW - 8;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ld_hi)      addr_d[AW-1:8] = din[HI_W-1:0];
    else if (ld_lo) addr_d[7:0]    = din;
    else if (inc)   addr_d         = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    addr_q <= '0;
    else if (ld_hi | ld_lo | inc)  addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/sfm_out_shift.sv
module sfm_out_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       shift,
  input  logic       clr,
  input  logic [7:0] din,
  output logic       so,
  output logic       oe
);
  logic [7:0] sh_q, sh_d;
  logic       oe_q, oe_d;

  always_comb begin
    sh_d = sh_q;
    oe_d = oe_q;
    if (clr) begin
      oe_d = 1'b0;
    end else if (load) begin
      sh_d = din;
      oe_d = 1'b1;
    end else if (shift) begin
      sh_d = {sh_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (clr | load | shift) begin
      sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign so = sh_q[7];
  assign oe = oe_q;
endmodule

// File: rtl/sfm_spi_slave.sv
module sfm_spi_slave
  import sfm_pkg::*;
#(
  parameter int AW          = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_si,
  output logic          spi_so,
  output logic          spi_so_oe,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_wr_ok,
  input  logic [7:0]    stat_rdata,
  output logic [7:0]    stat_wdata,
  output logic          stat_we,
  input  logic          sts_wr_ok,
  output logic          wel_set,
  output logic          wel_clr
);
  localparam int          NPIN    = 3;
  localparam logic [2:0]  PIN_RST = 3'b010; // {sck, cs_n, si}

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_i = rst_q[1];

  // pin synchronizers
  logic [NPIN-1:0] pin_raw, pin_s;
  assign pin_raw = {spi_sck, spi_cs_n, spi_si};
  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    sfm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n_i), .d(pin_raw[g]), .q(pin_s[g]));
  end

  logic sck_s, cs_s, si_s, sck_q, sck_rise, sck_fall;
  assign {sck_s, cs_s, si_s} = pin_s;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sck_q <= 1'b0;
    else          sck_q <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_s;

  // command state
  sfm_state_t state_q, state_d;
  logic [2:0] bit_q, bit_d;
  logic [6:0] shin_q, shin_d;
  logic       rd_q, rd_d;
  logic [7:0] byte_in;
  logic       ld_hi, ld_lo, inc;

  assign byte_in = {shin_q, si_s};

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    shin_d  = shin_q;
    rd_d    = rd_q;
    ld_hi   = 1'b0;
    ld_lo   = 1'b0;
    inc     = 1'b0;
    mem_we  = 1'b0;
    stat_we = 1'b0;
    wel_set = 1'b0;
    wel_clr = 1'b0;
    if (cs_s) begin
      state_d = ST_OP;
      bit_d   = '0;
    end else if (sck_rise) begin
      shin_d = byte_in[6:0];
      bit_d  = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        unique case (state_q)
          ST_OP: begin
            state_d = ST_SKIP;
            case (byte_in)
              OP_WREN:  wel_set = 1'b1;
              OP_WRDI:  wel_clr = 1'b1;
              OP_RDSR:  state_d = ST_RDSR;
              OP_WRSR:  state_d = ST_WRSR;
              OP_READ:  begin rd_d = 1'b1; state_d = ST_AHI; end
              OP_WRITE: begin rd_d = 1'b0; state_d = ST_AHI; end
              default:  state_d = ST_SKIP;
            endcase
          end
          ST_AHI: begin ld_hi = 1'b1; state_d = ST_ALO; end
          ST_ALO: begin ld_lo = 1'b1; state_d = rd_q ? ST_RD : ST_WR; end
          ST_WR:  begin mem_we = mem_wr_ok; inc = 1'b1; end
          ST_RD:  inc = 1'b1;
          ST_WRSR: begin stat_we = sts_wr_ok; state_d = ST_SKIP; end
          default: state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_OP;
      bit_q   <= '0;
      shin_q  <= '0;
      rd_q    <= 1'b0;
    end else if (cs_s | sck_rise) begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shin_q  <= shin_d;
      rd_q    <= rd_d;
    end
  end

  sfm_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n_i), .ld_hi(ld_hi), .ld_lo(ld_lo), .inc(inc),
    .din(byte_in), .addr(mem_addr));

  assign mem_wdata  = byte_in;
  assign stat_wdata = byte_in;

  // serial output
  logic out_phase, out_load, out_shift, so_raw;
  assign out_phase = (state_q == ST_RD) | (state_q == ST_RDSR);
  assign out_load  = sck_fall & out_phase & (bit_q == 3'd0);
  assign out_shift = sck_fall & out_phase & (bit_q != 3'd0);

  sfm_out_shift u_out (
    .clk(clk), .rst_n(rst_n_i), .load(out_load), .shift(out_shift), .clr(cs_s),
    .din((state_q == ST_RD) ? mem_rdata : stat_rdata),
    .so(so_raw), .oe(spi_so_oe));

  assign spi_so = so_raw & spi_so_oe;
endmodule

// File: rtl/sfm_spi_slave_chk.sv
module sfm_spi_slave_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_hi,
  input logic          sck_fall,
  input logic          spi_so,
  input logic          spi_so_oe,
  input logic          mem_we,
  input logic          stat_we,
  input logic          wel_set,
  input logic          wel_clr,
  input logic [AW-1:0] mem_addr
);
  p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_hi && spi_so_oe) |=> $stable(spi_so));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, stat_we, wel_set, wel_clr}));

  p_wr_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == AW'($past(mem_addr) + AW'(1))));

  p_no_out_on_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !spi_so_oe);

  p_hiz_after_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !spi_so_oe);
endmodule

bind sfm_spi_slave sfm_spi_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .cs_hi(cs_s), .sck_fall(sck_fall),
  .spi_so(spi_so), .spi_so_oe(spi_so_oe), .mem_we(mem_we), .stat_we(stat_we),
  .wel_set(wel_set), .wel_clr(wel_clr), .mem_addr(mem_addr));

// File: tb/sim_sfm_spi_slave.sv
`timescale 1ns/1ps
module sim_sfm_spi_slave;
  localparam int AW = 13;
  localparam int H  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0;
  logic spi_so, spi_so_oe, mem_we, stat_we, wel_set, wel_clr;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, stat_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] sreg = 8'h00;
  logic mem_wr_ok = 1'b1, sts_wr_ok = 1'b1;

  always #2 clk = ~clk;

  sfm_spi_slave #(.AW(AW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
    .spi_so(spi_so), .spi_so_oe(spi_so_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .mem_wr_ok(mem_wr_ok), .stat_rdata(sreg),
    .stat_wdata(stat_wdata), .stat_we(stat_we), .sts_wr_ok(sts_wr_ok),
    .wel_set(wel_set), .wel_clr(wel_clr));

  // array and status neighbour
  logic [7:0] bmem [int];
  logic [7:0] exp_mem [int];
  int n_mw = 0, n_sw = 0, n_set = 0, n_clr = 0;
  always @(posedge clk) begin
    if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
    if (stat_we) sreg <= stat_wdata;
    if (mem_we)  n_mw++;
    if (stat_we) n_sw++;
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
  end

  // per-clock check of SO enable against CS
  int cs_hi_cnt = 0, mon_err = 0;
  always @(negedge clk) begin
    if (spi_cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
    if (rst_n && cs_hi_cnt > 5 && spi_so_oe) mon_err++;
  end

  int errors = 0, checks = 0, mode = 0;
  logic oe_seen = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
  endfunction

  task automatic start(input int m);
    mode = m;
    spi_sck = (m == 3);
    @(negedge clk);
    spi_cs_n = 1'b0;
    oe_seen = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - n; i--) begin
      spi_sck = 1'b0;
      spi_si = tx[i];
      repeat (H) @(negedge clk);
      rx = {rx[6:0], spi_so};
      if (spi_so_oe) oe_seen = 1'b1;
      spi_sck = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic stop();
    if (mode == 0) begin
      spi_sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic do_write(input int m, input logic [15:0] a, input logic [7:0] d[$]);
    logic [7:0] rx;
    start(m);
    bits(8'h02, 8, rx);
    bits(a[15:8], 8, rx);
    bits(a[7:0], 8, rx);
    foreach (d[i]) begin
      bits(d[i], 8, rx);
      if (mem_wr_ok) exp_mem[(int'(a[12:0]) + i) % 8192] = d[i];
    end
    stop();
  endtask

  task automatic do_read(input int m, input logic [15:0] a, input int n,
                         input logic [7:0] fill, input string tag);
    logic [7:0] rx;
    start(m);
    bits(8'h03, 8, rx);
    bits(a[15:8], 8, rx);
    bits(a[7:0], 8, rx);
    for (int i = 0; i < n; i++) begin
      bits(fill, 8, rx);
      check(rx == exp_rd((int'(a[12:0]) + i) % 8192), tag, rx,
            exp_rd((int'(a[12:0]) + i) % 8192));
    end
    stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] rx;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // reset state (R11)
    check(spi_so_oe == 1'b0, "R11 reset oe", spi_so_oe, 0);
    check({mem_we, stat_we, wel_set, wel_clr} == 4'b0, "R2 reset strobes",
          {mem_we, stat_we, wel_set, wel_clr}, 0);

    // R2: latch requests in both modes
    start(0); bits(8'h06, 8, rx); stop();
    check(n_set == 1, "R2 WREN mode0", n_set, 1);
    start(3); bits(8'h04, 8, rx); stop();
    check(n_clr == 1, "R2 WRDI mode3", n_clr, 1);

    // R3: unknown op-code, more clocks after it
    start(0); bits(8'hA5, 8, rx); bits(8'h03, 8, rx); bits(8'h00, 8, rx); stop();
    check(n_mw + n_sw + n_set + n_clr == 2, "R3 no strobe", n_mw + n_sw + n_set + n_clr, 2);
    check(oe_seen == 1'b0, "R3 SO undriven", oe_seen, 0);

    // R4: CS rises during the op-code
    start(3); bits(8'h06, 5, rx); stop();
    check(n_set == 1, "R4 aborted op-code", n_set, 1);
    start(0); bits(8'h01, 7, rx); stop();
    check(n_sw == 0, "R4 aborted WRSR", n_sw, 0);

    // R7, R5: write with high address bits set, read back in both modes (R1)
    do_write(0, 16'hE010, '{8'h11, 8'h22, 8'h33});
    check(n_mw == 3, "R7 write strobes", n_mw, 3);
    do_read(3, 16'h0010, 4, 8'h00, "R5 R1 read mode3");
    do_read(0, 16'h2010, 3, 8'hFF, "R5 R1 read mode0 SI ignored");
    check(n_mw == 3, "R5 SI ignored no write", n_mw, 3);

    // R6, R7: wrap at the top address
    do_write(3, 16'h1FFE, '{8'hA1, 8'hB2, 8'hC3, 8'hD4});
    check(n_mw == 7, "R7 wrap strobes", n_mw, 7);
    do_read(0, 16'h1FFF, 3, 8'h5A, "R6 read wrap");
    do_read(3, 16'h1FFE, 4, 8'h00, "R7 write wrap");

    // R8: partial data byte discarded
    base = n_mw;
    start(0);
    bits(8'h02, 8, rx); bits(8'h01, 8, rx); bits(8'h00, 8, rx);
    bits(8'h77, 8, rx); bits(8'h99, 5, rx);
    exp_mem[16'h0100] = 8'h77;
    stop();
    check(n_mw == base + 1, "R8 partial byte", n_mw, base + 1);
    do_read(0, 16'h0100, 2, 8'h00, "R8 readback");

    // R9: permits withheld
    mem_wr_ok = 1'b0;
    do_write(0, 16'h0010, '{8'hEE, 8'hEE});
    check(n_mw == base + 1, "R9 mem write blocked", n_mw, base + 1);
    mem_wr_ok = 1'b1;
    do_read(3, 16'h0010, 2, 8'h00, "R9 data kept");

    // R10: status write and repeating status read
    start(3); bits(8'h01, 8, rx); bits(8'h8C, 8, rx); bits(8'h33, 8, rx); stop();
    check(n_sw == 1 && sreg == 8'h8C, "R10 WRSR", sreg, 8'h8C);
    sts_wr_ok = 1'b0;
    start(0); bits(8'h01, 8, rx); bits(8'h00, 8, rx); stop();
    check(n_sw == 1, "R9 status write blocked", n_sw, 1);
    start(0);
    bits(8'h05, 8, rx);
    for (int i = 0; i < 3; i++) begin
      bits(8'hFF, 8, rx);
      check(rx == 8'h8C, "R10 RDSR repeat", rx, 8'h8C);
    end
    stop();

    check(mon_err == 0, "R11 SO enable after CS", mon_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule